// File: doc/BRIEF.md
# PWM Channel with Event-Driven Output Actions

This block is one PWM channel. A prescaled counter runs against a 16-bit period in one of three directions: counting up, counting down, or rising and then falling. Two compare values, A and B, sit beside the period. The counter emits six kinds of event: reaching zero, reaching the period, and meeting compare A or compare B while rising or while falling. Each of the two outputs has its own action table. Every event in that table either leaves the output alone, forces it low, forces it high, or inverts it. The waveform is therefore made from these per-event actions rather than from a single duty comparison.

Software configures the channel through a byte-addressed write port and a combinational read port. Three enable inputs must all be high for the counter to run: a module-wide enable, a channel enable and a channel clock-on. While the channel is stopped, each output rests at the default level held in its own action register. The counter and the prescaler wait at zero until the channel starts again.

Top module: `pwm_aq_channel`

## Requirements
- R1: Registers sit at these byte offsets: 0x00 control, 0x14 period, 0x20 compare A, 0x24 compare B, 0x28 action A, 0x2C action B. The control register holds the mode in bits 1:0 and the divider in bits 27:16. The period and the two compare registers hold 16 bits each. Each action register holds its event fields in bits 11:0 and its default level in bit 16. Reads return only the implemented bits. Any other offset reads as 0. All registers reset to 0.
- R2: The counter advances only while the module enable, the channel enable and the channel clock-on are all 1. When any of the three is 0, the counter and the prescaler are cleared on the next clock.
- R3: While the channel runs, a counter step (a tick) happens once every divider+1 clocks. Outputs change only on a tick or while the channel is stopped.
- R4: In mode 0 the counter steps 0, 1, ..., PRD and then wraps to 0, so one cycle is PRD+1 ticks. Only rising events occur.
- R5: In mode 1 the counter steps down to 0 and then reloads PRD. The first tick after a start goes to PRD. Only falling events occur.
- R6: In mode 2 the counter rises from 0 to PRD and then falls back to 0, so one cycle is 2×PRD ticks.
- R7: Events are taken on the value the counter arrives at on a tick. Zero fires at 0. Period fires at PRD. A compare rising event fires at the compare value after an upward step, and a compare falling event fires after a downward step. The action fields are: zero bits 1:0, period bits 3:2, A-rising bits 5:4, A-falling bits 7:6, B-rising bits 9:8, B-falling bits 11:10. Codes are 0 no change, 1 low, 2 high, 3 invert.
- R8: When several events with a non-zero action fall on one tick, only one is applied. The order is zero, then period, then compare B, then compare A.
- R9: One clock after the channel is seen stopped, each output equals bit 16 of its action register, and it holds that level until the channel runs.
- R10: Writes to the period, compare and action registers affect the very next tick. There is no shadowing.
- R11: Mode value 3 behaves exactly as mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glb_en | input | 1 | Module-wide enable |
| ch_en | input | 1 | Channel enable |
| ch_clk_on | input | 1 | Channel clock-on |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| out_a | output | 1 | Output A |
| out_b | output | 1 | Output B |

## Verification
Several events can land on the same tick, and the priority rule decides which action wins. The bench provokes this by placing compare A and compare B on zero, where the zero event also fires. It also places compare A on the period value while leaving the period action empty. The duty it measures then shows which action took effect. A register write can also fall on the same clock as a tick. A behavioural model applies the tick with the old register values and the write afterwards, and it compares both outputs with the design on every clock.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;

    localparam int CNT_W_DEF = 16;
    localparam int DIV_W_DEF = 12;
    localparam int ADDR_W_DEF = 8;
    localparam int DATA_W_DEF = 32;

    localparam logic [7:0] OFS_CTL  = 8'h00;
    localparam logic [7:0] OFS_PRD  = 8'h14;
    localparam logic [7:0] OFS_CMPA = 8'h20;
    localparam logic [7:0] OFS_CMPB = 8'h24;
    localparam logic [7:0] OFS_ACTA = 8'h28;
    localparam logic [7:0] OFS_ACTB = 8'h2C;

    localparam int DIV_LSB  = 16;
    localparam int DFLT_BIT = 16;

    typedef enum logic [1:0] {
        MODE_UP   = 2'd0,
        MODE_DOWN = 2'd1,
        MODE_UPDN = 2'd2,
        MODE_RSVD = 2'd3
    } tb_mode_e;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_LOW    = 2'd1,
        ACT_HIGH   = 2'd2,
        ACT_TOGGLE = 2'd3
    } act_e;

    typedef struct packed {
        logic zero;
        logic period;
        logic a_up;
        logic a_dn;
        logic b_up;
        logic b_dn;
    } evt_t;

    typedef struct packed {
        logic dflt;
        act_e b_dn;
        act_e b_up;
        act_e a_dn;
        act_e a_up;
        act_e period;
        act_e zero;
    } act_cfg_t;

    function automatic act_e pick_action(evt_t ev, act_cfg_t cfg);
        act_e res;
        res = ACT_NONE;
        if (ev.zero && cfg.zero != ACT_NONE)            res = cfg.zero;
        else if (ev.period && cfg.period != ACT_NONE)   res = cfg.period;
        else if (ev.b_up && cfg.b_up != ACT_NONE)       res = cfg.b_up;
        else if (ev.b_dn && cfg.b_dn != ACT_NONE)       res = cfg.b_dn;
        else if (ev.a_up && cfg.a_up != ACT_NONE)       res = cfg.a_up;
        else if (ev.a_dn && cfg.a_dn != ACT_NONE)       res = cfg.a_dn;
        return res;
    endfunction

    function automatic logic apply_action(act_e act, logic cur);
        logic res;
        case (act)
            ACT_LOW:    res = 1'b0;
            ACT_HIGH:   res = 1'b1;
            ACT_TOGGLE: res = ~cur;
            default:    res = cur;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_aq_pkg::*;
#(
    parameter int CNT_W  = CNT_W_DEF,
    parameter int DIV_W  = DIV_W_DEF,
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output tb_mode_e          mode,
    output logic [DIV_W-1:0]  div,
    output logic [CNT_W-1:0]  prd,
    output logic [CNT_W-1:0]  cmpa,
    output logic [CNT_W-1:0]  cmpb,
    output act_cfg_t          cfg_a,
    output act_cfg_t          cfg_b
);
    localparam int ACT_FLD_W = 12;
    localparam logic [DATA_W-1:0] CTL_MASK =
        DATA_W'({{DIV_W{1'b1}}, {(DIV_LSB-2){1'b0}}, 2'b11});
    localparam logic [DATA_W-1:0] CNT_MASK = DATA_W'({CNT_W{1'b1}});
    localparam logic [DATA_W-1:0] ACT_MASK =
        DATA_W'({1'b1, {(DFLT_BIT-ACT_FLD_W){1'b0}}, {ACT_FLD_W{1'b1}}});

    logic [DATA_W-1:0] ctl_q, prd_q, cmpa_q, cmpb_q, acta_q, actb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            prd_q  <= '0;
            cmpa_q <= '0;
            cmpb_q <= '0;
            acta_q <= '0;
            actb_q <= '0;
        end else if (wr_en) begin
            case (addr)
                ADDR_W'(OFS_CTL):  ctl_q  <= wdata & CTL_MASK;
                ADDR_W'(OFS_PRD):  prd_q  <= wdata & CNT_MASK;
                ADDR_W'(OFS_CMPA): cmpa_q <= wdata & CNT_MASK;
                ADDR_W'(OFS_CMPB): cmpb_q <= wdata & CNT_MASK;
                ADDR_W'(OFS_ACTA): acta_q <= wdata & ACT_MASK;
                ADDR_W'(OFS_ACTB): actb_q <= wdata & ACT_MASK;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            ADDR_W'(OFS_CTL):  rdata = ctl_q;
            ADDR_W'(OFS_PRD):  rdata = prd_q;
            ADDR_W'(OFS_CMPA): rdata = cmpa_q;
            ADDR_W'(OFS_CMPB): rdata = cmpb_q;
            ADDR_W'(OFS_ACTA): rdata = acta_q;
            ADDR_W'(OFS_ACTB): rdata = actb_q;
            default:           rdata = '0;
        endcase
    end

    function automatic act_cfg_t unpack_act(logic [DATA_W-1:0] w);
        act_cfg_t c;
        c.zero   = act_e'(w[1:0]);
        c.period = act_e'(w[3:2]);
        c.a_up   = act_e'(w[5:4]);
        c.a_dn   = act_e'(w[7:6]);
        c.b_up   = act_e'(w[9:8]);
        c.b_dn   = act_e'(w[11:10]);
        c.dflt   = w[DFLT_BIT];
        return c;
    endfunction

    assign mode  = tb_mode_e'(ctl_q[1:0]);
    assign div   = ctl_q[DIV_LSB +: DIV_W];
    assign prd   = prd_q[CNT_W-1:0];
    assign cmpa  = cmpa_q[CNT_W-1:0];
    assign cmpb  = cmpb_q[CNT_W-1:0];
    assign cfg_a = unpack_act(acta_q);
    assign cfg_b = unpack_act(actb_q);
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_aq_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF,
    parameter int DIV_W = DIV_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  tb_mode_e         mode,
    input  logic [DIV_W-1:0] div,
    input  logic [CNT_W-1:0] prd,
    output logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             cnt_up,
    output logic [CNT_W-1:0] nxt_cnt,
    output logic             nxt_up
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [DIV_W-1:0] psc;

    assign tick = run && (psc >= div);

    always_comb begin
        nxt_cnt = cnt;
        nxt_up  = cnt_up;
        case (mode)
            MODE_DOWN: begin
                nxt_up  = 1'b0;
                nxt_cnt = (cnt == '0 || cnt > prd) ? prd : cnt - ONE;
            end
            MODE_UPDN: begin
                if (cnt_up) begin
                    if (cnt < prd) begin
                        nxt_cnt = cnt + ONE;
                    end else if (cnt == '0) begin
                        nxt_cnt = '0;
                    end else begin
                        nxt_cnt = cnt - ONE;
                        nxt_up  = 1'b0;
                    end
                end else begin
                    if (cnt != '0) begin
                        nxt_cnt = cnt - ONE;
                    end else begin
                        nxt_up  = 1'b1;
                        nxt_cnt = (prd != '0) ? ONE : '0;
                    end
                end
            end
            default: begin
                nxt_up  = 1'b1;
                nxt_cnt = (cnt >= prd) ? '0 : cnt + ONE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            psc    <= '0;
            cnt    <= '0;
            cnt_up <= (mode != MODE_DOWN);
        end else if (tick) begin
            psc    <= '0;
            cnt    <= nxt_cnt;
            cnt_up <= nxt_up;
        end else begin
            psc    <= psc + DIV_W'(1);
        end
    end
endmodule

// File: rtl/pwm_evt_detect.sv
module pwm_evt_detect
    import pwm_aq_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic [CNT_W-1:0] arr_cnt,
    input  logic             arr_up,
    input  logic [CNT_W-1:0] prd,
    input  logic [CNT_W-1:0] cmpa,
    input  logic [CNT_W-1:0] cmpb,
    output evt_t             evt
);
    always_comb begin
        evt.zero   = (arr_cnt == '0);
        evt.period = (arr_cnt == prd);
        evt.a_up   = (arr_cnt == cmpa) &&  arr_up;
        evt.a_dn   = (arr_cnt == cmpa) && !arr_up;
        evt.b_up   = (arr_cnt == cmpb) &&  arr_up;
        evt.b_dn   = (arr_cnt == cmpb) && !arr_up;
    end
endmodule

// File: rtl/pwm_action_unit.sv
module pwm_action_unit
    import pwm_aq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     run,
    input  logic     tick,
    input  evt_t     evt,
    input  act_cfg_t cfg,
    output logic     pin
);
    always_ff @(posedge clk) begin
        if (rst)
            pin <= 1'b0;
        else if (!run)
            pin <= cfg.dflt;
        else if (tick)
            pin <= apply_action(pick_action(evt, cfg), pin);
    end
endmodule

// File: rtl/pwm_aq_channel.sv
module pwm_aq_channel
    import pwm_aq_pkg::*;
#(
    parameter int CNT_W  = CNT_W_DEF,
    parameter int DIV_W  = DIV_W_DEF,
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              glb_en,
    input  logic              ch_en,
    input  logic              ch_clk_on,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              out_a,
    output logic              out_b
);
    localparam int N_OUT = 2;

    tb_mode_e         mode;
    logic [DIV_W-1:0] div;
    logic [CNT_W-1:0] prd, cmpa, cmpb, cnt, nxt_cnt;
    logic             cnt_up, nxt_up, tick, run;
    act_cfg_t         cfg_a, cfg_b;
    evt_t             evt;
    act_cfg_t         cfg_v [N_OUT];
    logic [N_OUT-1:0] pins;

    assign run = glb_en && ch_en && ch_clk_on;

    pwm_regs #(.CNT_W(CNT_W), .DIV_W(DIV_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .mode(mode), .div(div), .prd(prd), .cmpa(cmpa),
        .cmpb(cmpb), .cfg_a(cfg_a), .cfg_b(cfg_b)
    );

    pwm_timebase #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_tb (
        .clk(clk), .rst(rst), .run(run), .mode(mode), .div(div), .prd(prd),
        .tick(tick), .cnt(cnt), .cnt_up(cnt_up), .nxt_cnt(nxt_cnt), .nxt_up(nxt_up)
    );

    pwm_evt_detect #(.CNT_W(CNT_W)) u_evt (
        .arr_cnt(nxt_cnt), .arr_up(nxt_up), .prd(prd), .cmpa(cmpa),
        .cmpb(cmpb), .evt(evt)
    );

    assign cfg_v[0] = cfg_a;
    assign cfg_v[1] = cfg_b;

    for (genvar g = 0; g < N_OUT; g++) begin : g_aq
        pwm_action_unit u_aq (
            .clk(clk), .rst(rst), .run(run), .tick(tick), .evt(evt),
            .cfg(cfg_v[g]), .pin(pins[g])
        );
    end

    assign out_a = pins[0];
    assign out_b = pins[1];
endmodule

// File: rtl/pwm_aq_checker.sv
module pwm_aq_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             run,
    input logic             tick,
    input logic [1:0]       mode,
    input logic [CNT_W-1:0] prd,
    input logic [CNT_W-1:0] cnt,
    input logic             cnt_up,
    input logic             out_a,
    input logic             out_b,
    input logic             dflt_a,
    input logic             dflt_b
);
    p_idle_clear_r2: assert property (@(posedge clk) disable iff (rst)
        !run |=> cnt == '0);

    p_hold_between_ticks_r3: assert property (@(posedge clk) disable iff (rst)
        (run && !tick) |=> ($stable(cnt) && $stable(out_a) && $stable(out_b)));

    p_up_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (run && tick && mode == 2'd0 && cnt >= prd) |=> cnt == '0);

    p_down_reload_r5: assert property (@(posedge clk) disable iff (rst)
        (run && tick && mode == 2'd1 && cnt == '0) |=> cnt == $past(prd));

    p_updn_turn_r6: assert property (@(posedge clk) disable iff (rst)
        (run && tick && mode == 2'd2 && cnt_up && cnt >= prd && cnt != '0)
        |=> (!cnt_up && cnt == $past(cnt) - CNT_W'(1)));

    p_default_level_r9: assert property (@(posedge clk) disable iff (rst)
        !run |=> (out_a == $past(dflt_a) && out_b == $past(dflt_b)));
endmodule

bind pwm_aq_channel pwm_aq_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .run(run), .tick(tick), .mode(mode), .prd(prd),
    .cnt(cnt), .cnt_up(cnt_up), .out_a(out_a), .out_b(out_b),
    .dflt_a(cfg_a.dflt), .dflt_b(cfg_b.dflt)
);

// File: tb/pwm_aq_channel_tb.sv
module pwm_aq_channel_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        glb_en = 1'b0, ch_en = 1'b0, ch_clk_on = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        out_a, out_b;

    always #2.5 clk = ~clk;

    pwm_aq_channel u_dut (
        .clk(clk), .rst(rst), .glb_en(glb_en), .ch_en(ch_en), .ch_clk_on(ch_clk_on),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .out_a(out_a), .out_b(out_b)
    );

    int    n_checks = 0;
    int    n_errors = 0;
    int    cycles = 0;
    bit    done = 0;
    bit    cmp_on = 0;
    string cur_tag = "R2";

    // behavioural reference state
    int m_mode, m_div, m_prd, m_cmpa, m_cmpb, m_acta, m_actb;
    int m_cnt, m_psc, m_up, m_oa, m_ob;

    task automatic check(string tag, int actual, int expected);
        n_checks++;
        if (actual != expected) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", tag, actual, expected, $time);
        end
    endtask

    function automatic int fld(int act, int pos);
        return (act >> (2 * pos)) & 3;
    endfunction

    function automatic int resolve(int act, int cur, bit z, bit p, bit au, bit ad, bit bu, bit bd);
        int code = 0;
        // priority list: zero, period, B rising, B falling, A rising, A falling
        if (z && fld(act, 0) != 0) code = fld(act, 0);
        else if (p && fld(act, 1) != 0) code = fld(act, 1);
        else if (bu && fld(act, 4) != 0) code = fld(act, 4);
        else if (bd && fld(act, 5) != 0) code = fld(act, 5);
        else if (au && fld(act, 2) != 0) code = fld(act, 2);
        else if (ad && fld(act, 3) != 0) code = fld(act, 3);
        case (code)
            1: return 0;
            2: return 1;
            3: return 1 - cur;
            default: return cur;
        endcase
    endfunction

    task automatic model_tick();
        int c = m_cnt;
        if (m_mode == 1) begin
            m_up = 0;
            if (c == 0 || c > m_prd) m_cnt = m_prd; else m_cnt = c - 1;
        end else if (m_mode == 2) begin
            if (m_up == 1) begin
                if (c < m_prd) m_cnt = c + 1;
                else if (c != 0) begin m_cnt = c - 1; m_up = 0; end
            end else begin
                if (c > 0) m_cnt = c - 1;
                else begin m_up = 1; m_cnt = (m_prd > 0) ? 1 : 0; end
            end
        end else begin
            m_up = 1;
            m_cnt = (c >= m_prd) ? 0 : c + 1;
        end
        m_oa = resolve(m_acta, m_oa, m_cnt == 0, m_cnt == m_prd,
                       m_cnt == m_cmpa && m_up == 1, m_cnt == m_cmpa && m_up == 0,
                       m_cnt == m_cmpb && m_up == 1, m_cnt == m_cmpb && m_up == 0);
        m_ob = resolve(m_actb, m_ob, m_cnt == 0, m_cnt == m_prd,
                       m_cnt == m_cmpa && m_up == 1, m_cnt == m_cmpa && m_up == 0,
                       m_cnt == m_cmpb && m_up == 1, m_cnt == m_cmpb && m_up == 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_mode = 0; m_div = 0; m_prd = 0; m_cmpa = 0; m_cmpb = 0;
            m_acta = 0; m_actb = 0; m_cnt = 0; m_psc = 0; m_up = 1; m_oa = 0; m_ob = 0;
        end else begin
            if (!(glb_en && ch_en && ch_clk_on)) begin
                m_cnt = 0; m_psc = 0; m_up = (m_mode == 1) ? 0 : 1;
                m_oa = (m_acta >> 16) & 1;
                m_ob = (m_actb >> 16) & 1;
            end else if (m_psc >= m_div) begin
                m_psc = 0;
                model_tick();
            end else begin
                m_psc++;
            end
            if (wr_en) begin
                case (addr)
                    8'h00: begin m_mode = wdata[1:0]; m_div = wdata[27:16]; end
                    8'h14: m_prd = wdata[15:0];
                    8'h20: m_cmpa = wdata[15:0];
                    8'h24: m_cmpb = wdata[15:0];
                    8'h28: m_acta = wdata & 32'h0001_0FFF;
                    8'h2C: m_actb = wdata & 32'h0001_0FFF;
                    default: ;
                endcase
            end
            if (m_mode == 3) m_mode = 0; // R11: reserved mode acts as mode 0
        end
    end

    always @(negedge clk) begin
        if (cmp_on && !rst) begin
            check({cur_tag, " out_a vs model"}, out_a, m_oa);
            check({cur_tag, " out_b vs model"}, out_b, m_ob);
        end
    end

    always @(posedge clk) begin
        if (cycles > 100000 && !done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=%0d expected=<100000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(string tag, input logic [7:0] a, input int expected);
        @(negedge clk);
        addr = a;
        #1;
        check(tag, rdata, expected);
    endtask

    task automatic measure(int n, output int ha, output int hb);
        ha = 0; hb = 0;
        repeat (n) begin
            @(negedge clk);
            ha += out_a;
            hb += out_b;
        end
    endtask

    task automatic stop_ch();
        @(negedge clk);
        ch_clk_on = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic start_ch();
        @(negedge clk);
        glb_en = 1'b1; ch_en = 1'b1; ch_clk_on = 1'b1;
    endtask

    initial begin
        int ha, hb;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset out_a", out_a, 0);
        check("R1 reset out_b", out_b, 0);
        rd_check("R1 reset period", 8'h14, 0);
        cmp_on = 1;

        // R1: field masks and map
        wr(8'h00, 32'hFFFF_FFFF);
        rd_check("R1 ctl readback", 8'h00, 32'h0FFF_0003);
        wr(8'h14, 32'hABCD_1234);
        rd_check("R1 prd readback", 8'h14, 32'h0000_1234);
        wr(8'h28, 32'hFFFF_FFFF);
        rd_check("R1 act readback", 8'h28, 32'h0001_0FFF);
        rd_check("R1 unmapped read", 8'h04, 0);
        wr(8'h28, 0);

        // R3 R4 R7: up mode, divider 1
        cur_tag = "R4";
        wr(8'h00, 32'h0001_0000);
        wr(8'h14, 9); wr(8'h20, 3);
        wr(8'h28, 32'h012);   // zero high, A rising low
        wr(8'h2C, 32'h00C);   // period invert
        start_ch();
        repeat (60) @(negedge clk);
        measure(40, ha, hb);
        check("R4 up duty A (3 of 10 ticks, div 1)", ha, 12);
        check("R3 R7 invert period B", hb, 20);
        stop_ch();

        // R6: up-down
        cur_tag = "R6";
        wr(8'h00, 2); wr(8'h14, 8); wr(8'h20, 5); wr(8'h24, 2);
        wr(8'h28, 32'h060);    // A rising high, A falling low
        wr(8'h2C, 32'h1_0900); // default 1, B rising low, B falling high
        start_ch();
        repeat (40) @(negedge clk);
        measure(32, ha, hb);
        check("R6 updown duty A", ha, 12);
        check("R6 updown duty B", hb, 8);
        stop_ch();

        // R5: down mode, rising events ignored
        cur_tag = "R5";
        wr(8'h00, 1); wr(8'h14, 7); wr(8'h20, 2);
        wr(8'h28, 32'h048);    // period high, A falling low
        wr(8'h2C, 32'h030);    // A rising invert: never fires in mode 1
        start_ch();
        repeat (30) @(negedge clk);
        measure(16, ha, hb);
        check("R5 down duty A", ha, 10);
        check("R5 rising event ignored B", hb, 0);
        stop_ch();

        // R8: compare at zero, zero over A, B over A
        cur_tag = "R8";
        wr(8'h00, 0); wr(8'h14, 5); wr(8'h20, 0); wr(8'h24, 0);
        wr(8'h28, 32'h012);
        wr(8'h2C, 32'h1_0120); // default 1, A rising high, B rising low
        start_ch();
        repeat (20) @(negedge clk);
        measure(12, ha, hb);
        check("R8 zero beats A", ha, 12);
        check("R8 B beats A", hb, 0);
        stop_ch();

        // R7: compare at period with empty period action, zero invert
        cur_tag = "R7";
        wr(8'h20, 5);
        wr(8'h28, 32'h012);
        wr(8'h2C, 32'h003);
        start_ch();
        repeat (20) @(negedge clk);
        measure(12, ha, hb);
        check("R7 compare equals PRD", ha, 10);
        check("R7 zero invert", hb, 6);

        // R10: immediate compare write while running
        cur_tag = "R10";
        wr(8'h14, 9); wr(8'h20, 3);
        repeat (25) @(negedge clk);
        wr(8'h20, 7);
        repeat (25) @(negedge clk);
        measure(20, ha, hb);
        check("R10 new compare in effect", ha, 14);

        // R11: reserved mode behaves as mode 0
        cur_tag = "R11";
        stop_ch();
        wr(8'h00, 3); wr(8'h14, 4); wr(8'h20, 2);
        start_ch();
        repeat (20) @(negedge clk);
        measure(10, ha, hb);
        check("R11 mode 3 duty", ha, 4);

        // R9 R2: default levels after disable
        cur_tag = "R9";
        wr(8'h28, 32'h1_0012);
        wr(8'h2C, 32'h0_0030);
        repeat (7) @(negedge clk);
        glb_en = 1'b0;
        repeat (2) @(negedge clk);
        check("R9 default A after disable", out_a, 1);
        check("R9 default B after disable", out_b, 0);
        cur_tag = "R2";
        glb_en = 1'b1; ch_en = 1'b1; ch_clk_on = 1'b0;
        repeat (10) @(negedge clk);
        check("R2 clock-on low holds A", out_a, 1);
        ch_clk_on = 1'b1; ch_en = 1'b0;
        repeat (10) @(negedge clk);
        check("R2 channel enable low holds A", out_a, 1);

        cmp_on = 0;
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule